// File: doc/BRIEF.md
# 8-bit Timer/Counter with Compare Output and PWM

This block is an 8-bit timer/counter with one compare channel and a waveform generator behind it. On each enabled count tick the counter advances according to one of four sequences: free-running up-count, up-count that restarts at the compare value, single-slope PWM, or dual-slope PWM that counts up to the maximum and back down to zero. The compare channel drives an output flip-flop. In the two counting modes a compare match toggles, clears or sets that flip-flop. In the two PWM modes the flip-flop follows a duty level derived from the count and the compare value, in true or inverted polarity.

Software reaches the block through a plain register-write port. The write strobe, the register select and the write data are sampled on the clock edge. There is no stream data path, so there is no valid/ready handshake and nothing ever waits. In the PWM modes the compare value is double-buffered: a write lands in a holding register and moves into the active comparator only at the top of the count. This keeps every PWM period whole. The output flip-flop can be preset while the pin is still an input, and the waveform reaches the pin only when the direction input selects output. Overflow and compare flags are sticky until they are cleared with a write-one-to-clear input.

Top module: `wave_timer`

## Requirements
- R1: After reset the count is 0, both flags are 0, the mode is free-running (mode 00) and the compare output is disconnected, so wave_oe and wave_o are 0.
- R2: Writing reg_sel 2 loads the control byte: bits 1:0 select the mode and bits 3:2 select the output action. In mode 00 each tick adds one to the count, wrapping from 0xFF to 0x00. A compare match never clears the count in this mode, and the overflow flag is set by the tick taken at 0xFF.
- R3: In mode 01 a tick taken while the count equals the active compare value moves the count to 0. Overflow is set only by a tick taken at 0xFF.
- R4: In mode 11 the count runs up to 0xFF and then down to 0x00, turning at each end. The overflow flag is set by the tick taken at 0x00 while counting down, and not at 0xFF.
- R5: In modes 00 and 01 a compare match applies the output action: 01 toggles, 10 clears, 11 sets and 00 leaves the output unchanged. In every mode the compare flag is set by a tick taken while the count equals the active compare value.
- R6: In mode 10 (single-slope PWM) each tick sets the output to the level for the new count: high when count <= compare for action 10, and the opposite for action 11. Action 01 disconnects the pin in both PWM modes. With no tick and no preset, the output does not change in a PWM mode.
- R7: In mode 11 the level for action 10 is high when count < compare, and the opposite for action 11.
- R8: In both PWM modes a compare value of 0x00 gives a constant low level and 0xFF a constant high level for action 10.
- R9: Writing reg_sel 1 updates the compare value. In modes 00 and 01 the new value takes effect at once. In the PWM modes it goes to a buffer that moves into the active compare only on the tick taken at 0xFF while counting up.
- R10: A force_cmp pulse in mode 00 or 01 applies the output action without setting the compare flag. In a PWM mode it has no effect.
- R11: Writing reg_sel 3 presets the output flip-flop from data bit 0. wave_oe is pin_dir while the output is connected, and 0 otherwise. wave_o equals the flip-flop while wave_oe is 1, and 0 otherwise.
- R12: Flags stay set until a 1 on flag_clr (bit 0 clears overflow, bit 1 clears compare). A flag event in the same cycle as its clear leaves the flag set.
- R13: Writing reg_sel 0 loads the count. A tick in the same cycle is dropped: it causes no step, no match and no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable from the prescaler |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 count, 1 compare, 2 control, 3 output preset |
| reg_wdata | input | 8 | Register write data |
| force_cmp | input | 1 | Force-compare strobe |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 overflow, bit 1 compare |
| pin_dir | input | 1 | Pin direction, 1 = output |
| count_o | output | 8 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare-match flag |
| wave_o | output | 1 | Waveform toward the pin |
| wave_oe | output | 1 | Pin output enable |

## Verification
Two pairs of functions can fall on the same edge. The first pair is a flag-setting event and a software clear of that flag. The second is a count write and a tick. The bench provokes the first by raising tick at count 0xFF, and then at a compare match, in the same cycle as the matching flag_clr bit; the flag must read 1 afterwards. It provokes the second by driving a count write together with tick, with the count at 0xFF. The count must show the written value, and the overflow flag must stay 0.

// File: rtl/wt_pkg.sv
package wt_pkg;
  typedef enum logic [1:0] {
    WM_FREE  = 2'b00,
    WM_RESET = 2'b01,
    WM_FAST  = 2'b10,
    WM_DUAL  = 2'b11
  } wmode_t;

  typedef enum logic [1:0] {
    OA_NONE   = 2'b00,
    OA_TOGGLE = 2'b01,
    OA_CLEAR  = 2'b10,
    OA_SET    = 2'b11
  } oact_t;

  typedef enum logic [1:0] {
    RS_COUNT  = 2'b00,
    RS_CMP    = 2'b01,
    RS_CTRL   = 2'b10,
    RS_PRESET = 2'b11
  } rsel_t;
endpackage

// File: rtl/wt_counter.sv
module wt_counter
  import wt_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          cnt_wr,
  input  logic [CW-1:0] wdata,
  input  wmode_t        mode,
  input  logic [CW-1:0] cmp_act,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt,
  output logic          down_q,
  output logic          top_evt,
  output logic          ovf_evt
);
  localparam logic [CW-1:0] MAXV = '1;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic dn_nxt;
  logic at_top;
  logic at_ovf;

  always_comb begin
    cnt_nxt = cnt_q + ONE;
    dn_nxt  = 1'b0;
    at_top  = 1'b0;
    at_ovf  = 1'b0;
    case (mode)
      WM_FREE: at_ovf = (cnt_q == MAXV);
      WM_RESET: begin
        at_ovf = (cnt_q == MAXV);
        if (cnt_q == cmp_act) cnt_nxt = '0;
      end
      WM_FAST: begin
        at_top = (cnt_q == MAXV);
        at_ovf = at_top;
      end
      WM_DUAL: begin
        if (down_q) begin
          if (cnt_q == '0) begin
            cnt_nxt = ONE;
            at_ovf  = 1'b1;
          end else begin
            cnt_nxt = cnt_q - ONE;
            dn_nxt  = 1'b1;
          end
        end else if (cnt_q == MAXV) begin
          cnt_nxt = MAXV - ONE;
          dn_nxt  = 1'b1;
          at_top  = 1'b1;
        end
      end
    endcase
  end

  assign top_evt = step & at_top;
  assign ovf_evt = step & at_ovf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      if (cnt_wr)    cnt_q <= wdata;
      else if (step) cnt_q <= cnt_nxt;
      if (mode != WM_DUAL) down_q <= 1'b0;
      else if (step)       down_q <= dn_nxt;
    end
  end
endmodule

// File: rtl/wt_cmpbuf.sv
module wt_cmpbuf #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_wr,
  input  logic [CW-1:0] wdata,
  input  logic          pwm,
  input  logic          load,
  output logic [CW-1:0] act_q,
  output logic [CW-1:0] act_nxt
);
  logic [CW-1:0] hold_q;

  always_comb begin
    if (load)                act_nxt = cmp_wr ? wdata : hold_q;
    else if (cmp_wr && !pwm) act_nxt = wdata;
    else                     act_nxt = act_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      act_q  <= '0;
    end else begin
      act_q <= act_nxt;
      if (cmp_wr) hold_q <= wdata;
    end
  end
endmodule

// File: rtl/wt_wavegen.sv
module wt_wavegen
  import wt_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          force_ok,
  input  wmode_t        mode,
  input  oact_t         act,
  input  logic [CW-1:0] cnt_q,
  input  logic [CW-1:0] cnt_nxt,
  input  logic [CW-1:0] cmp_q,
  input  logic [CW-1:0] cmp_nxt,
  input  logic          preset_wr,
  input  logic          preset_val,
  output logic          oc_q,
  output logic          match_evt
);
  localparam logic [CW-1:0] MAXV = '1;

  function automatic logic single_lvl(input logic [CW-1:0] c, input logic [CW-1:0] a);
    return (a == MAXV) | ((a != '0) & (c <= a));
  endfunction

  function automatic logic dual_lvl(input logic [CW-1:0] c, input logic [CW-1:0] a);
    return (a == MAXV) | (c < a);
  endfunction

  logic pwm;
  logic lvl;
  logic oc_n;

  assign pwm       = mode[1];
  assign match_evt = step & (cnt_q == cmp_q);
  assign lvl       = (mode == WM_FAST) ? single_lvl(cnt_nxt, cmp_nxt)
                                       : dual_lvl(cnt_nxt, cmp_nxt);

  always_comb begin
    oc_n = oc_q;
    if (preset_wr) begin
      oc_n = preset_val;
    end else if (pwm) begin
      if (step && act[1]) oc_n = lvl ^ act[0];
    end else if (match_evt || force_ok) begin
      case (act)
        OA_TOGGLE: oc_n = ~oc_q;
        OA_CLEAR:  oc_n = 1'b0;
        OA_SET:    oc_n = 1'b1;
        default:   oc_n = oc_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) oc_q <= 1'b0;
    else        oc_q <= oc_n;
  end
endmodule

// File: rtl/wt_flags.sv
module wt_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovf_evt,
  input  logic       match_evt,
  input  logic [1:0] clr,
  output logic       ovf_q,
  output logic       cmp_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      cmp_q <= 1'b0;
    end else begin
      ovf_q <= ovf_evt | (ovf_q & ~clr[0]);
      cmp_q <= match_evt | (cmp_q & ~clr[1]);
    end
  end
endmodule

// File: rtl/wave_timer.sv
module wave_timer
  import wt_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [CW-1:0] reg_wdata,
  input  logic          force_cmp,
  input  logic [1:0]    flag_clr,
  input  logic          pin_dir,
  output logic [CW-1:0] count_o,
  output logic          ovf_flag,
  output logic          cmp_flag,
  output logic          wave_o,
  output logic          wave_oe
);
  wmode_t        mode_q;
  oact_t         com_q;
  logic          cnt_wr, cmp_wr, ctl_wr, pre_wr;
  logic          step;
  logic [CW-1:0] cnt_nxt;
  logic [CW-1:0] cmp_act, cmp_nxt;
  logic          down_w, top_evt, ovf_evt, match_evt;
  logic          oc_q;
  logic          connected;

  assign cnt_wr = reg_wr & (reg_sel == RS_COUNT);
  assign cmp_wr = reg_wr & (reg_sel == RS_CMP);
  assign ctl_wr = reg_wr & (reg_sel == RS_CTRL);
  assign pre_wr = reg_wr & (reg_sel == RS_PRESET);
  assign step   = tick & ~cnt_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= WM_FREE;
      com_q  <= OA_NONE;
    end else if (ctl_wr) begin
      mode_q <= wmode_t'(reg_wdata[1:0]);
      com_q  <= oact_t'(reg_wdata[3:2]);
    end
  end

  wt_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .cnt_wr(cnt_wr),
    .wdata(reg_wdata), .mode(mode_q), .cmp_act(cmp_act),
    .cnt_q(count_o), .cnt_nxt(cnt_nxt), .down_q(down_w),
    .top_evt(top_evt), .ovf_evt(ovf_evt)
  );

  wt_cmpbuf #(.CW(CW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cmp_wr(cmp_wr), .wdata(reg_wdata),
    .pwm(mode_q[1]), .load(top_evt), .act_q(cmp_act), .act_nxt(cmp_nxt)
  );

  wt_wavegen #(.CW(CW)) u_wave (
    .clk(clk), .rst_n(rst_n), .step(step),
    .force_ok(force_cmp & ~mode_q[1]), .mode(mode_q), .act(com_q),
    .cnt_q(count_o), .cnt_nxt(cnt_nxt), .cmp_q(cmp_act), .cmp_nxt(cmp_nxt),
    .preset_wr(pre_wr), .preset_val(reg_wdata[0]),
    .oc_q(oc_q), .match_evt(match_evt)
  );

  wt_flags u_flg (
    .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .match_evt(match_evt),
    .clr(flag_clr), .ovf_q(ovf_flag), .cmp_q(cmp_flag)
  );

  assign connected = (com_q != OA_NONE) & ~(mode_q[1] & (com_q == OA_TOGGLE));
  assign wave_oe   = pin_dir & connected;
  assign wave_o    = wave_oe & oc_q;
endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          reg_wr,
  input logic [1:0]    reg_sel,
  input logic [CW-1:0] reg_wdata,
  input logic          force_cmp,
  input logic [1:0]    flag_clr,
  input logic [CW-1:0] count_o,
  input logic          ovf_flag,
  input logic          cmp_flag,
  input logic [1:0]    mode,
  input logic          down_q,
  input logic          top_evt,
  input logic [CW-1:0] cmp_act,
  input logic          oc_q
);
  logic cw_now;
  assign cw_now = reg_wr && (reg_sel == 2'b00);

  // R2
  cnt_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cw_now && mode == 2'b00) |=> (count_o == $past(count_o) + CW'(1)));

  // R4
  dual_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cw_now && mode == 2'b11 && down_q && count_o != '0)
      |=> (count_o == $past(count_o) - CW'(1)));

  // R12
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr[0]) |=> ovf_flag);

  // R10
  force_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_cmp && !tick && !flag_clr[1]) |=> (cmp_flag == $past(cmp_flag)));

  // R9
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && !top_evt) |=> $stable(cmp_act));

  // R6
  pwm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && !tick && !(reg_wr && reg_sel == 2'b11)) |=> $stable(oc_q));

  // R13
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cw_now |=> (count_o == $past(reg_wdata)));
endmodule

bind wave_timer wt_checker #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .force_cmp(force_cmp), .flag_clr(flag_clr),
  .count_o(count_o), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag),
  .mode(mode_q), .down_q(down_w), .top_evt(top_evt), .cmp_act(cmp_act),
  .oc_q(oc_q)
);

// File: tb/wave_timer_tb_top.sv
module wave_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'b00;
  logic [7:0] reg_wdata = 8'h00;
  logic       force_cmp = 1'b0;
  logic [1:0] flag_clr = 2'b00;
  logic       pin_dir = 1'b0;
  logic [7:0] count_o;
  logic       ovf_flag, cmp_flag, wave_o, wave_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wave_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .force_cmp(force_cmp), .flag_clr(flag_clr),
    .pin_dir(pin_dir), .count_o(count_o), .ovf_flag(ovf_flag),
    .cmp_flag(cmp_flag), .wave_o(wave_o), .wave_oe(wave_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic step();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic clr_flags();
    flag_clr = 2'b11;
    @(negedge clk);
    flag_clr = 2'b00;
  endtask

  task automatic t_reset();
    chk("R1 count", count_o, 8'h00);
    chk("R1 ovf", {7'd0, ovf_flag}, 8'h00);
    chk("R1 cmp", {7'd0, cmp_flag}, 8'h00);
    chk("R1 oe", {7'd0, wave_oe}, 8'h00);
    chk("R1 wave", {7'd0, wave_o}, 8'h00);
  endtask

  task automatic t_free();
    pin_dir = 1'b1;
    wr(2'd2, 8'h04);
    wr(2'd1, 8'hFE);
    wr(2'd0, 8'hFD);
    wr(2'd3, 8'h00);
    clr_flags();
    step();
    chk("R2 count FE", count_o, 8'hFE);
    chk("R5 no match yet", {7'd0, cmp_flag}, 8'h00);
    step();
    chk("R5 toggle on match", {7'd0, wave_o}, 8'h01);
    chk("R5 cmp flag", {7'd0, cmp_flag}, 8'h01);
    chk("R2 not cleared on match", count_o, 8'hFF);
    chk("R2 no ovf before FF tick", {7'd0, ovf_flag}, 8'h00);
    step();
    chk("R2 wrap", count_o, 8'h00);
    chk("R2 ovf at FF", {7'd0, ovf_flag}, 8'h01);
    chk("R5 hold off match", {7'd0, wave_o}, 8'h01);
  endtask

  task automatic t_restart();
    wr(2'd2, 8'h0D);
    wr(2'd1, 8'h03);
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h00);
    clr_flags();
    for (int i = 0; i < 3; i++) step();
    chk("R3 reach compare", count_o, 8'h03);
    chk("R5 set not yet", {7'd0, wave_o}, 8'h00);
    step();
    chk("R3 restart at compare", count_o, 8'h00);
    chk("R5 set action", {7'd0, wave_o}, 8'h01);
    chk("R3 no ovf", {7'd0, ovf_flag}, 8'h00);
    wr(2'd2, 8'h09);
    for (int i = 0; i < 4; i++) step();
    chk("R5 clear action", {7'd0, wave_o}, 8'h00);
    chk("R3 restart again", count_o, 8'h00);
  endtask

  task automatic t_force();
    wr(2'd2, 8'h04);
    wr(2'd3, 8'h00);
    clr_flags();
    force_cmp = 1'b1; @(negedge clk); force_cmp = 1'b0;
    chk("R10 force toggles", {7'd0, wave_o}, 8'h01);
    chk("R10 force no flag", {7'd0, cmp_flag}, 8'h00);
    wr(2'd2, 8'h0A);
    force_cmp = 1'b1; @(negedge clk); force_cmp = 1'b0;
    chk("R10 force ignored in PWM", {7'd0, wave_o}, 8'h01);
  endtask

  task automatic t_fast();
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h10);
    wr(2'd2, 8'h0A);
    wr(2'd1, 8'h40);
    wr(2'd0, 8'h0E);
    clr_flags();
    step();
    chk("R6 high below compare", {7'd0, wave_o}, 8'h01);
    step();
    chk("R6 high at compare", {7'd0, wave_o}, 8'h01);
    step();
    chk("R6 low above compare", {7'd0, wave_o}, 8'h00);
    wr(2'd0, 8'h1F);
    step();
    chk("R9 old compare still active", {7'd0, wave_o}, 8'h00);
    wr(2'd0, 8'hFE);
    step();
    chk("R6 low at FF", {7'd0, wave_o}, 8'h00);
    step();
    chk("R6 wrap to 0", count_o, 8'h00);
    chk("R2 ovf at top in fast PWM", {7'd0, ovf_flag}, 8'h01);
    chk("R6 high at bottom", {7'd0, wave_o}, 8'h01);
    wr(2'd0, 8'h1F);
    step();
    chk("R9 new compare loaded at top", {7'd0, wave_o}, 8'h01);
    wr(2'd0, 8'h40);
    step();
    chk("R6 low past new compare", {7'd0, wave_o}, 8'h00);
    wr(2'd2, 8'h0E);
    wr(2'd0, 8'h1F);
    step();
    chk("R6 inverted low", {7'd0, wave_o}, 8'h00);
    wr(2'd0, 8'h50);
    step();
    chk("R6 inverted high", {7'd0, wave_o}, 8'h01);
    wr(2'd2, 8'h06);
    chk("R6 action 01 disconnects PWM", {6'd0, wave_oe, wave_o}, 8'h00);
  endtask

  task automatic t_fast_const();
    wr(2'd2, 8'h0A);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hFF);
    step();
    chk("R8 zero compare low at 0", {7'd0, wave_o}, 8'h00);
    step();
    chk("R8 zero compare low at 1", {7'd0, wave_o}, 8'h00);
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'hFF);
    step();
    chk("R8 full compare high at 0", {7'd0, wave_o}, 8'h01);
    wr(2'd0, 8'hFE);
    step();
    chk("R8 full compare high at FF", {7'd0, wave_o}, 8'h01);
  endtask

  task automatic t_dual();
    wr(2'd2, 8'h0B);
    wr(2'd1, 8'h80);
    wr(2'd0, 8'hFE);
    clr_flags();
    step();
    chk("R4 reach FF", count_o, 8'hFF);
    step();
    chk("R4 turn down at FF", count_o, 8'hFE);
    chk("R4 no ovf at FF", {7'd0, ovf_flag}, 8'h00);
    chk("R7 low above compare", {7'd0, wave_o}, 8'h00);
    wr(2'd0, 8'h81);
    clr_flags();
    step();
    chk("R7 low at compare", {7'd0, wave_o}, 8'h00);
    step();
    chk("R5 match flag in dual slope", {7'd0, cmp_flag}, 8'h01);
    chk("R7 high below compare", {7'd0, wave_o}, 8'h01);
    chk("R9 loaded at turning point", count_o, 8'h7F);
    wr(2'd0, 8'h01);
    step();
    chk("R4 down to 0", count_o, 8'h00);
    chk("R4 no ovf yet", {7'd0, ovf_flag}, 8'h00);
    step();
    chk("R4 turn up at 0", count_o, 8'h01);
    chk("R4 ovf at bottom", {7'd0, ovf_flag}, 8'h01);
    step();
    chk("R4 counting up", count_o, 8'h02);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hFF);
    step();
    chk("R8 dual zero compare low", {7'd0, wave_o}, 8'h00);
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'h00);
    step();
    step();
    wr(2'd0, 8'hFF);
    step();
    chk("R8 dual full compare high", {7'd0, wave_o}, 8'h01);
  endtask

  task automatic t_coincide();
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hFF);
    clr_flags();
    tick = 1'b1; flag_clr = 2'b01;
    @(negedge clk);
    tick = 1'b0; flag_clr = 2'b00;
    chk("R12 ovf set beats clear", {7'd0, ovf_flag}, 8'h01);
    flag_clr = 2'b01; @(negedge clk); flag_clr = 2'b00;
    chk("R12 ovf cleared", {7'd0, ovf_flag}, 8'h00);
    wr(2'd1, 8'h05);
    wr(2'd0, 8'h05);
    clr_flags();
    tick = 1'b1; flag_clr = 2'b10;
    @(negedge clk);
    tick = 1'b0; flag_clr = 2'b00;
    chk("R12 cmp set beats clear", {7'd0, cmp_flag}, 8'h01);
    wr(2'd0, 8'hFF);
    clr_flags();
    tick = 1'b1; reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h20;
    @(negedge clk);
    tick = 1'b0; reg_wr = 1'b0;
    chk("R13 write beats tick", count_o, 8'h20);
    chk("R13 dropped tick no ovf", {7'd0, ovf_flag}, 8'h00);
  endtask

  task automatic t_pin();
    wr(2'd2, 8'h04);
    wr(2'd3, 8'h01);
    pin_dir = 1'b0;
    @(negedge clk);
    chk("R11 preset hidden while input", {6'd0, wave_oe, wave_o}, 8'h00);
    pin_dir = 1'b1;
    @(negedge clk);
    chk("R11 preset shows when output", {6'd0, wave_oe, wave_o}, 8'h03);
    wr(2'd2, 8'h00);
    chk("R11 action 00 disconnects", {6'd0, wave_oe, wave_o}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_free();
    t_restart();
    t_force();
    t_fast();
    t_fast_const();
    t_dual();
    t_coincide();
    t_pin();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule